// File: doc/BRIEF.md
# Carry-Free Multi-Operand Adder

This block adds N_OPS unsigned operands of N_OPS bits each and delivers their exact sum on a result of N_OPS + ceil(log2 N_OPS) bits. No carry ripples from column to column, and there is no carry-save tree. Each column is handled on its own. For column i, the operands are cut down to their i lowest bits and summed. A fixed set of interval comparisons on that partial total gives the least significant bit of the multi-bit carry entering the column. The result bit is then the parity of that carry bit together with the column's operand bits. The result bits at and above index N_OPS come straight from interval comparisons on the full total.

All interval bounds are constants worked out at elaboration from N_OPS. A single register stage captures the result. A caller presents a flattened operand vector together with a valid strobe, and picks up the sum one cycle later.

Top module: `moa_threshold_adder`

## Requirements
- R1: While `rst` is sampled high on a rising edge, `res_valid` and `res_sum` are cleared to zero at that edge.
- R2: `res_valid` is high in exactly those cycles that follow a rising edge at which `in_valid` was high and `rst` was low.
- R3: When `res_valid` is high, `res_sum` equals the arithmetic sum of all operands. Operand k sits at `op_bus[k*N_OPS +: N_OPS]`, unsigned.
- R4: The result width is large enough that the all-ones case, N_OPS*(2^N_OPS - 1), comes out exactly with no truncation.
- R5: Result bit 0 is the parity of bit 0 of every operand, because no carry enters column 0.
- R6: For 1 <= i < N_OPS, result bit i is the parity of bit i of every operand together with bit 0 of floor(T_i / 2^i). T_i is the sum of the operands with each operand kept to its i lowest bits.
- R7: Result bits from index N_OPS upward equal the matching bits of the full operand total.
- R8: In a cycle after a rising edge with `in_valid` low, `res_sum` keeps its previous value.
- R9: All-zero operands give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand vector is present and is to be added |
| op_bus | input | N_OPS*N_OPS | Flattened operands, operand k at bits k*N_OPS upward |
| res_valid | output | 1 | `res_sum` holds a fresh result |
| res_sum | output | N_OPS+ceil(log2 N_OPS) | Registered sum of the operands |

## Verification
Every result is due exactly one cycle after its operands are accepted, because the only register on the path is the output stage. The bench keeps a one-cycle model of `in_valid` to predict `res_valid`. It queues one expected entry per accepted vector and removes the oldest entry on the falling edge after each predicted valid cycle, so each comparison lands on the cycle in which the result first appears. In the idle cycles between results, the bench compares the held value against the last result.

// File: rtl/moa_pkg.sv
package moa_pkg;

  // Result width that holds n_ops * (2^n_ops - 1) without loss.
  function automatic int result_width(int n_ops);
    return n_ops + $clog2(n_ops);
  endfunction

  // Largest value the operands can reach when each is cut to 'cols' low bits.
  function automatic longint column_max(int n_ops, int cols);
    return longint'(n_ops) * ((longint'(1) << cols) - 1);
  endfunction

  // Count of intervals [(2j+1)*2^b, (2j+2)*2^b - 1] that start at or below max_val.
  function automatic int interval_count(longint max_val, int bitpos);
    longint q;
    q = max_val >> bitpos;
    return int'((q + 1) / 2);
  endfunction

endpackage

// File: rtl/moa_column_sum.sv
module moa_column_sum #(
  parameter int N_OPS = 8,
  parameter int COLS  = 1,
  parameter int SUM_W = 11
) (
  input  logic [N_OPS*COLS-1:0] low_bits,
  output logic [SUM_W-1:0]      total
);
  // Total of the operands truncated to COLS bits (each slice already cut).
  always_comb begin
    total = '0;
    for (int k = 0; k < N_OPS; k++) begin
      total = total + SUM_W'(low_bits[k*COLS +: COLS]);
    end
  end
endmodule

// File: rtl/moa_interval_bit.sv
module moa_interval_bit
  import moa_pkg::*;
#(
  parameter int     SUM_W   = 11,
  parameter int     BITPOS  = 1,
  parameter longint MAX_VAL = 255
) (
  input  logic [SUM_W-1:0] total,
  output logic             hit
);
  localparam int NI = interval_count(MAX_VAL, BITPOS);

  // Bit BITPOS of 'total' is one exactly when total falls in an odd block of
  // size 2^BITPOS. Each block is bounded by two constant threshold tests.
  generate
    if (NI == 0) begin : g_none
      assign hit = 1'b0;
    end else begin : g_iv
      logic [NI-1:0] in_range;
      for (genvar j = 0; j < NI; j++) begin : g_j
        localparam longint LO = longint'(2*j + 1) << BITPOS;
        localparam longint HI = (longint'(2*j + 2) << BITPOS) - 1;
        logic above_lo;
        logic below_hi;
        assign above_lo    = {1'b0, total} >= (SUM_W+1)'(LO);
        assign below_hi    = {1'b0, total} <= (SUM_W+1)'(HI);
        assign in_range[j] = above_lo & below_hi;
      end
      assign hit = |in_range;
    end
  endgenerate
endmodule

// File: rtl/moa_parity.sv
module moa_parity #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] bits,
  output logic             odd
);
  assign odd = ^bits;
endmodule

// File: rtl/moa_threshold_adder.sv
module moa_threshold_adder #(
  parameter  int N_OPS = 8,
  localparam int OUT_W = moa_pkg::result_width(N_OPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [N_OPS*N_OPS-1:0] op_bus,
  output logic                   res_valid,
  output logic [OUT_W-1:0]       res_sum
);
  import moa_pkg::*;

  logic [OUT_W-1:0] sum_comb;

  // Column 0: no carry enters, result is the plain parity of the bit-0 column.
  logic [N_OPS-1:0] col0_bits;
  for (genvar k = 0; k < N_OPS; k++) begin : g_col0
    assign col0_bits[k] = op_bus[k*N_OPS];
  end
  moa_parity #(.WIDTH(N_OPS)) u_par0 (.bits(col0_bits), .odd(sum_comb[0]));

  // Columns 1 .. N_OPS-1: carry low bit from interval tests, then wide parity.
  for (genvar i = 1; i < N_OPS; i++) begin : g_col
    logic [N_OPS*i-1:0] low_bits;
    logic [OUT_W-1:0]   part_total;
    logic               carry_lsb;
    logic [N_OPS:0]     par_in;

    for (genvar k = 0; k < N_OPS; k++) begin : g_op
      assign low_bits[k*i +: i] = op_bus[k*N_OPS +: i];
      assign par_in[k]          = op_bus[k*N_OPS + i];
    end
    assign par_in[N_OPS] = carry_lsb;

    moa_column_sum #(.N_OPS(N_OPS), .COLS(i), .SUM_W(OUT_W)) u_tsum (
      .low_bits(low_bits),
      .total   (part_total)
    );

    moa_interval_bit #(
      .SUM_W  (OUT_W),
      .BITPOS (i),
      .MAX_VAL(column_max(N_OPS, i))
    ) u_carry (
      .total(part_total),
      .hit  (carry_lsb)
    );

    moa_parity #(.WIDTH(N_OPS+1)) u_par (.bits(par_in), .odd(sum_comb[i]));
  end

  // Upper result bits: interval tests on the untruncated total.
  logic [OUT_W-1:0] full_total;
  moa_column_sum #(.N_OPS(N_OPS), .COLS(N_OPS), .SUM_W(OUT_W)) u_fsum (
    .low_bits(op_bus),
    .total   (full_total)
  );

  for (genvar b = N_OPS; b < OUT_W; b++) begin : g_high
    moa_interval_bit #(
      .SUM_W  (OUT_W),
      .BITPOS (b),
      .MAX_VAL(column_max(N_OPS, N_OPS))
    ) u_hbit (
      .total(full_total),
      .hit  (sum_comb[b])
    );
  end

  // Output register stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_sum   <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_sum <= sum_comb;
    end
  end
endmodule

// File: rtl/moa_threshold_adder_chk.sv
module moa_threshold_adder_chk #(
  parameter  int N_OPS = 8,
  localparam int OUT_W = moa_pkg::result_width(N_OPS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [N_OPS*N_OPS-1:0] op_bus,
  input logic                   res_valid,
  input logic [OUT_W-1:0]       res_sum
);
  logic [OUT_W-1:0] ref_total;
  always_comb begin
    ref_total = '0;
    for (int k = 0; k < N_OPS; k++) begin
      ref_total = ref_total + OUT_W'(op_bus[k*N_OPS +: N_OPS]);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && res_sum == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  // R3
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (res_sum == $past(ref_total)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_sum));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (longint'(res_sum) <= moa_pkg::column_max(N_OPS, N_OPS)));
endmodule

bind moa_threshold_adder moa_threshold_adder_chk #(.N_OPS(N_OPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_bus   (op_bus),
  .res_valid(res_valid),
  .res_sum  (res_sum)
);

// File: tb/moa_threshold_adder_bench.sv
module moa_threshold_adder_bench;
  localparam int N     = 8;
  localparam int OW    = N + $clog2(N);
  localparam int CLK_P = 10;

  typedef struct {
    logic [N*N-1:0] ops;
    logic [OW-1:0]  exp;
    int             kind; // 0 random, 1 all ones, 2 all zero
  } item_t;

  logic           clk = 1'b0;
  logic           rst;
  logic           in_valid;
  logic [N*N-1:0] op_bus;
  logic           res_valid;
  logic [OW-1:0]  res_sum;

  moa_threshold_adder #(.N_OPS(N)) u_moa_threshold_adder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_bus(op_bus),
    .res_valid(res_valid), .res_sum(res_sum)
  );

  always #(CLK_P/2) clk = ~clk;

  item_t         sb_q[$];
  int            n_checks = 0;
  int            n_fail   = 0;
  logic          exp_valid = 1'b0;
  logic          have_prev = 1'b0;
  logic [OW-1:0] prev_sum  = '0;
  bit            finished  = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] model_sum(input logic [N*N-1:0] ops);
    logic [OW-1:0] s = '0;
    for (int k = 0; k < N; k++) s = s + OW'(ops[k*N +: N]);
    return s;
  endfunction

  // Per-bit expectation from the column formulation (R5, R6).
  function automatic logic [N-1:0] model_low_bits(input logic [N*N-1:0] ops);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      longint trunc = 0;
      logic   p     = 1'b0;
      for (int k = 0; k < N; k++) begin
        trunc += longint'(ops[k*N +: N]) & ((longint'(1) << i) - 1);
        p ^= ops[k*N + i];
      end
      r[i] = p ^ logic'((trunc >> i) & 1);
    end
    return r;
  endfunction

  // Model of the one-cycle valid path (R2).
  always @(posedge clk) exp_valid <= rst ? 1'b0 : in_valid;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(res_valid == exp_valid, "R2", longint'(res_valid), longint'(exp_valid));
      if (exp_valid && sb_q.size() > 0) begin
        item_t it;
        logic [N-1:0] lowexp;
        it = sb_q.pop_front();
        lowexp = model_low_bits(it.ops);
        check(res_sum == it.exp, "R3", longint'(res_sum), longint'(it.exp));
        check(res_sum[0] == lowexp[0], "R5", longint'(res_sum[0]), longint'(lowexp[0]));
        check(res_sum[N-1:1] == lowexp[N-1:1], "R6", longint'(res_sum[N-1:1]), longint'(lowexp[N-1:1]));
        check(res_sum[OW-1:N] == it.exp[OW-1:N], "R7", longint'(res_sum[OW-1:N]), longint'(it.exp[OW-1:N]));
        if (it.kind == 1)
          check(longint'(res_sum) == longint'(N) * ((longint'(1) << N) - 1), "R4",
                longint'(res_sum), longint'(N) * ((longint'(1) << N) - 1));
        if (it.kind == 2)
          check(res_sum == '0, "R9", longint'(res_sum), 0);
        prev_sum  <= res_sum;
        have_prev <= 1'b1;
      end else if (!exp_valid && have_prev) begin
        check(res_sum == prev_sum, "R8", longint'(res_sum), longint'(prev_sum));
      end
    end
  end

  task automatic send(input logic [N*N-1:0] ops, input int kind);
    item_t it;
    @(negedge clk);
    op_bus   = ops;
    in_valid = 1'b1;
    it.ops = ops; it.exp = model_sum(ops); it.kind = kind;
    sb_q.push_back(it);
  endtask

  task automatic idle(input logic [N*N-1:0] ops);
    @(negedge clk);
    op_bus   = ops;   // changing operands while idle must not disturb the output
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst      = 1'b1;
    repeat (2) @(negedge clk);
    check(res_valid == 1'b0, "R1", longint'(res_valid), 0);
    check(res_sum == '0, "R1", longint'(res_sum), 0);
    rst       = 1'b0;
    have_prev = 1'b0;
  endtask

  function automatic logic [N*N-1:0] rand_ops();
    logic [N*N-1:0] v;
    for (int w = 0; w < N*N; w += 32) v[w +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_bus = '0;
    repeat (3) @(posedge clk);
    do_reset();
    send('0, 2);                      // R9
    send('1, 1);                      // R4
    idle(rand_ops());                 // R8
    idle(rand_ops());
    send({{(N*N-N){1'b0}}, {N{1'b1}}}, 0);
    for (int k = 0; k < N; k++) begin
      logic [N*N-1:0] v = '0;
      v[k*N] = 1'b1;
      send(v, 0);                     // single low bit per operand, R5
    end
    for (int r = 0; r < 300; r++) begin
      send(rand_ops(), 0);
      if (r % 7 == 3) idle(rand_ops());
    end
    send('1, 1);
    idle('0);
    do_reset();                       // R1 mid-run
    send(rand_ops(), 0);
    idle('0);
    idle('0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule